// File: doc/BRIEF.md
# Display-Safe Memory Clock Switch Sequencer

This block changes the memory clock without disturbing the picture on up to two display heads. A single-cycle `start` launches a fixed sequence. First it takes two back-to-back samples of each head's scan position to find out which heads are running. Next it waits for the start of a vertical blanking interval on every running head and blocks that head's memory fetches. It then puts the DRAM into self-refresh, rewrites one or two memory PLLs from a divider set that is already computed, and lets the PLL settle. Finally it brings the DRAM back into normal refresh and restores display fetches inside a blanking interval.

Fetch blocking works on each head's 8-bit clock-mode register. The block captures the value read at launch, writes it back with the fetch-block bit set, and at the end writes the captured value back unchanged. The PLL control word is merged into the current register contents. Only the bits the sequence owns are changed. Every blanking wait is bounded by a cycle timeout. When a wait times out, the block skips ahead to the exit steps and reports the failure together with `done`.

Top module: `mclk_swap_seq`

## Requirements
- R1: A head counts as active only if its `head_scan` value differs between the samples taken in the first and second cycles after `start` is accepted. An inactive head receives no clock-mode write at any point in the sequence.
- R2: For each active head, taken in index order, the block waits for `head_vblank` to read 0 and then 1. The fetch-block write (the captured mode value with bit 5 set) appears exactly 2 cycles after the first high sample of that rising edge. All of these writes happen before any DRAM command.
- R3: DRAM preparation occurs in this order: one `dram_precharge` cycle, then two `dram_refresh` cycles, then `dram_auto_ref_en` low, then `dram_self_refresh` high.
- R4: `clk_src_sel` goes from 2'b11 to 2'b00 after self-refresh is entered and before the PLL write. It returns to 2'b11 after the PLL write. The PLL write happens only while self-refresh is on, auto-refresh is off and `clk_src_sel` is 2'b00.
- R5: `pll_ctrl` equals `pll_ctrl_cur` outside mask 0xC0771100. Inside the mask it holds: bit 31 = 1, bits 18:16 = log2p, bits 22:20 = min(bias_p + log2p, max_p), bit 30 = `two_stage`, bit 8 = not `two_stage`, bit 12 = 0.
- R6: `pll_coef` is {16'b0, n1, m1} in single-stage mode and {n2, m2, n1, m1} in two-stage mode.
- R7: The PLL write strobe `pll_wr` is a single cycle. Its value is 2'b01 when `dual_pll` is 0 and 2'b11 when `dual_pll` is 1. Both PLLs receive the same control word and coefficient.
- R8: `dram_self_refresh` falls exactly `settle_cycles` + 3 cycles after the cycle in which `pll_wr` is high.
- R9: On exit, self-refresh drops first, then auto-refresh enable rises. After that, each active head in turn gets its captured mode value written back unchanged. Each such write appears 2 cycles after a high `head_vblank` sample.
- R10: If a blanking wait lasts TMO_CYCLES cycles, the block skips the remaining entry, DRAM and PLL steps and still runs the exit steps. `error` is then high in the same single cycle as `done`. Otherwise `error` stays low.
- R11: `busy` is high from the cycle after `start` is accepted until `done`. A `start` seen while busy is ignored. `done` is a single-cycle pulse, once per accepted start.
- R12: After reset: `busy`, `done`, `error`, all strobes and `dram_self_refresh` are low, `dram_auto_ref_en` is high, and `clk_src_sel` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, ignored while busy |
| dual_pll | input | 1 | 1: program both memory PLLs |
| two_stage | input | 1 | 1: two-stage divider layout |
| log2p | input | 3 | Post-divider exponent |
| bias_p | input | 3 | Post-divider bias |
| max_p | input | 3 | Post-divider ceiling |
| n1 | input | 8 | First-stage multiplier |
| m1 | input | 8 | First-stage divider |
| n2 | input | 8 | Second-stage multiplier |
| m2 | input | 8 | Second-stage divider |
| settle_cycles | input | SETTLE_W | PLL lock wait before self-refresh exit |
| head_scan | input | NHEAD*SCAN_W | Scan position per head |
| head_vblank | input | NHEAD | Vertical blanking flag per head |
| head_mode_rd | input | NHEAD*8 | Current clock-mode register per head |
| head_mode_wr | output | NHEAD | Clock-mode write strobe per head |
| head_mode_wdata | output | NHEAD*8 | Clock-mode write data per head |
| dram_precharge | output | 1 | Precharge-all command, one cycle |
| dram_refresh | output | 1 | Refresh command, one per high cycle |
| dram_auto_ref_en | output | 1 | Auto-refresh enable level |
| dram_self_refresh | output | 1 | Self-refresh request level |
| clk_src_sel | output | 2 | Memory clock source select field |
| pll_ctrl_cur | input | 32 | Present PLL control register value |
| pll_wr | output | NPLL | PLL register write strobe per PLL |
| pll_ctrl | output | 32 | Merged PLL control word |
| pll_coef | output | 32 | PLL coefficient word |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout flag, valid with done |

## Verification
Every output is a register set by the state machine one edge after the state that decides it. The bench therefore records the cycle number of each output event at the falling edge and compares distances between events instead of absolute times. A fetch-block write must sit exactly 2 samples after a low-to-high blanking edge, and an exit restore exactly 2 samples after a high blanking sample. The self-refresh fall must trail the PLL strobe by exactly `settle_cycles` + 3. The DRAM and clock-select events must appear in strictly increasing cycle order. The control word, coefficient and write data are captured in the cycle their strobe is high, and compared with values the bench computes from the divider inputs.

// File: rtl/mclk_swap_pkg.sv
package mclk_swap_pkg;

  localparam logic [31:0] PLL_OWN_MASK   = 32'hC0771100;
  localparam int          FETCH_OFF_BIT  = 5;
  localparam logic [1:0]  SEL_NORMAL     = 2'b11;
  localparam logic [1:0]  SEL_BYPASS     = 2'b00;

  typedef enum logic [4:0] {
    S_IDLE, S_SAMP_A, S_SAMP_B, S_ENT_SEL, S_W_LOW, S_W_HIGH, S_BLOCK,
    S_PRE, S_REF1, S_REF2, S_AREF_OFF, S_SR_ON, S_SEL_CLR, S_PLL,
    S_SEL_SET, S_SETTLE, S_SR_OFF, S_AREF_ON, S_EX_SEL, S_EX_WAIT,
    S_RESTORE, S_FIN
  } seq_state_e;

  typedef struct packed {
    logic       two_stage;
    logic [2:0] log2p;
    logic [2:0] bias_p;
    logic [2:0] max_p;
    logic [7:0] n1;
    logic [7:0] m1;
    logic [7:0] n2;
    logic [7:0] m2;
  } div_set_t;

endpackage

// File: rtl/mclk_word_pack.sv
module mclk_word_pack
  import mclk_swap_pkg::*;
(
  input  div_set_t    div,
  output logic [31:0] ctrl_bits,
  output logic [31:0] coef
);

  logic [3:0] p_sum;
  logic [2:0] p_eff;

  always_comb begin
    p_sum = {1'b0, div.bias_p} + {1'b0, div.log2p};
    p_eff = (p_sum > {1'b0, div.max_p}) ? div.max_p : p_sum[2:0];

    ctrl_bits        = '0;
    ctrl_bits[31]    = 1'b1;
    ctrl_bits[30]    = div.two_stage;
    ctrl_bits[22:20] = p_eff;
    ctrl_bits[18:16] = div.log2p;
    ctrl_bits[8]     = ~div.two_stage;

    if (div.two_stage) coef = {div.n2, div.m2, div.n1, div.m1};
    else               coef = {16'h0000, div.n1, div.m1};
  end

endmodule

// File: rtl/mclk_head_probe.sv
module mclk_head_probe #(
  parameter int SCAN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_a,
  input  logic              cap_b,
  input  logic [SCAN_W-1:0] scan,
  input  logic [7:0]        mode_rd,
  output logic              active,
  output logic [7:0]        saved_mode
);

  logic [SCAN_W-1:0] scan_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_first <= '0;
      saved_mode <= '0;
      active     <= 1'b0;
    end else begin
      if (cap_a) begin
        scan_first <= scan;
        saved_mode <= mode_rd;
      end
      if (cap_b) active <= (scan != scan_first);
    end
  end

endmodule

// File: rtl/mclk_cycle_timer.sv
module mclk_cycle_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         hit
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (!hit)   cnt <= cnt + 1'b1;
  end

  assign hit = (cnt == limit);

endmodule

// File: rtl/mclk_swap_seq.sv
module mclk_swap_seq
  import mclk_swap_pkg::*;
#(
  parameter int NHEAD      = 2,
  parameter int NPLL       = 2,
  parameter int SCAN_W     = 16,
  parameter int SETTLE_W   = 8,
  parameter int TMO_CYCLES = 4000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      dual_pll,
  input  logic                      two_stage,
  input  logic [2:0]                log2p,
  input  logic [2:0]                bias_p,
  input  logic [2:0]                max_p,
  input  logic [7:0]                n1,
  input  logic [7:0]                m1,
  input  logic [7:0]                n2,
  input  logic [7:0]                m2,
  input  logic [SETTLE_W-1:0]       settle_cycles,
  input  logic [NHEAD*SCAN_W-1:0]   head_scan,
  input  logic [NHEAD-1:0]          head_vblank,
  input  logic [NHEAD*8-1:0]        head_mode_rd,
  output logic [NHEAD-1:0]          head_mode_wr,
  output logic [NHEAD*8-1:0]        head_mode_wdata,
  output logic                      dram_precharge,
  output logic                      dram_refresh,
  output logic                      dram_auto_ref_en,
  output logic                      dram_self_refresh,
  output logic [1:0]                clk_src_sel,
  input  logic [31:0]               pll_ctrl_cur,
  output logic [NPLL-1:0]           pll_wr,
  output logic [31:0]               pll_ctrl,
  output logic [31:0]               pll_coef,
  output logic                      busy,
  output logic                      done,
  output logic                      error
);

  localparam int HW    = $clog2(NHEAD + 1);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);
  localparam int CNT_W = (TMO_W > SETTLE_W) ? TMO_W : SETTLE_W;
  localparam logic [HW-1:0] LAST_H = HW'(NHEAD);

  seq_state_e     state;
  logic [HW-1:0]  h;
  logic           err_f;

  // per-head probes
  logic [NHEAD-1:0] act;
  logic [7:0]       saved [NHEAD];
  logic             cap_a, cap_b;

  assign cap_a = (state == S_SAMP_A);
  assign cap_b = (state == S_SAMP_B);

  generate
    for (genvar g = 0; g < NHEAD; g++) begin : g_head
      mclk_head_probe #(.SCAN_W(SCAN_W)) u_probe (
        .clk        (clk),
        .rst        (rst),
        .cap_a      (cap_a),
        .cap_b      (cap_b),
        .scan       (head_scan[g*SCAN_W +: SCAN_W]),
        .mode_rd    (head_mode_rd[g*8 +: 8]),
        .active     (act[g]),
        .saved_mode (saved[g])
      );
    end
  endgenerate

  // selected head view
  logic       act_cur, vbl_cur;
  logic [7:0] saved_cur;

  always_comb begin
    act_cur   = 1'b0;
    vbl_cur   = 1'b0;
    saved_cur = '0;
    for (int i = 0; i < NHEAD; i++) begin
      if (h == HW'(i)) begin
        act_cur   = act[i];
        vbl_cur   = head_vblank[i];
        saved_cur = saved[i];
      end
    end
  end

  // divider word packing
  div_set_t    div;
  logic [31:0] ctrl_bits, coef_word;

  assign div = '{two_stage: two_stage, log2p: log2p, bias_p: bias_p,
                 max_p: max_p, n1: n1, m1: m1, n2: n2, m2: m2};

  mclk_word_pack u_pack (
    .div       (div),
    .ctrl_bits (ctrl_bits),
    .coef      (coef_word)
  );

  // shared wait / settle timer
  logic             waiting, tmr_hit;
  logic [CNT_W-1:0] tmr_limit;

  assign waiting = (state == S_W_LOW) || (state == S_W_HIGH) ||
                   (state == S_SETTLE) || (state == S_EX_WAIT);
  assign tmr_limit = (state == S_SETTLE) ? CNT_W'(settle_cycles)
                                         : CNT_W'(TMO_CYCLES);

  mclk_cycle_timer #(.W(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (!waiting),
    .limit (tmr_limit),
    .hit   (tmr_hit)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state             <= S_IDLE;
      h                 <= '0;
      err_f             <= 1'b0;
      busy              <= 1'b0;
      done              <= 1'b0;
      error             <= 1'b0;
      dram_precharge    <= 1'b0;
      dram_refresh      <= 1'b0;
      dram_auto_ref_en  <= 1'b1;
      dram_self_refresh <= 1'b0;
      clk_src_sel       <= SEL_NORMAL;
      pll_wr            <= '0;
      pll_ctrl          <= '0;
      pll_coef          <= '0;
      head_mode_wr      <= '0;
      head_mode_wdata   <= '0;
    end else begin
      done           <= 1'b0;
      error          <= 1'b0;
      dram_precharge <= 1'b0;
      dram_refresh   <= 1'b0;
      pll_wr         <= '0;
      head_mode_wr   <= '0;

      unique case (state)
        S_IDLE: if (start) begin
          busy  <= 1'b1;
          err_f <= 1'b0;
          state <= S_SAMP_A;
        end
        S_SAMP_A: state <= S_SAMP_B;
        S_SAMP_B: begin
          h     <= '0;
          state <= S_ENT_SEL;
        end
        S_ENT_SEL: begin
          if (h == LAST_H)  state <= S_PRE;
          else if (!act_cur) h    <= h + 1'b1;
          else               state <= S_W_LOW;
        end
        S_W_LOW: begin
          if (!vbl_cur) state <= S_W_HIGH;
          else if (tmr_hit) begin
            err_f <= 1'b1;
            state <= S_SR_OFF;
          end
        end
        S_W_HIGH: begin
          if (vbl_cur) state <= S_BLOCK;
          else if (tmr_hit) begin
            err_f <= 1'b1;
            state <= S_SR_OFF;
          end
        end
        S_BLOCK: begin
          for (int i = 0; i < NHEAD; i++) begin
            if (h == HW'(i)) begin
              head_mode_wr[i]         <= 1'b1;
              head_mode_wdata[i*8 +: 8] <= saved_cur | (8'd1 << FETCH_OFF_BIT);
            end
          end
          h     <= h + 1'b1;
          state <= S_ENT_SEL;
        end
        S_PRE: begin
          dram_precharge <= 1'b1;
          state          <= S_REF1;
        end
        S_REF1: begin
          dram_refresh <= 1'b1;
          state        <= S_REF2;
        end
        S_REF2: begin
          dram_refresh <= 1'b1;
          state        <= S_AREF_OFF;
        end
        S_AREF_OFF: begin
          dram_auto_ref_en <= 1'b0;
          state            <= S_SR_ON;
        end
        S_SR_ON: begin
          dram_self_refresh <= 1'b1;
          state             <= S_SEL_CLR;
        end
        S_SEL_CLR: begin
          clk_src_sel <= SEL_BYPASS;
          state       <= S_PLL;
        end
        S_PLL: begin
          pll_wr   <= dual_pll ? {NPLL{1'b1}} : NPLL'(1);
          pll_ctrl <= (pll_ctrl_cur & ~PLL_OWN_MASK) | (ctrl_bits & PLL_OWN_MASK);
          pll_coef <= coef_word;
          state    <= S_SEL_SET;
        end
        S_SEL_SET: begin
          clk_src_sel <= SEL_NORMAL;
          state       <= S_SETTLE;
        end
        S_SETTLE: if (tmr_hit) state <= S_SR_OFF;
        S_SR_OFF: begin
          dram_self_refresh <= 1'b0;
          state             <= S_AREF_ON;
        end
        S_AREF_ON: begin
          dram_auto_ref_en <= 1'b1;
          h                <= '0;
          state            <= S_EX_SEL;
        end
        S_EX_SEL: begin
          if (h == LAST_H)   state <= S_FIN;
          else if (!act_cur) h     <= h + 1'b1;
          else               state <= S_EX_WAIT;
        end
        S_EX_WAIT: begin
          if (vbl_cur) state <= S_RESTORE;
          else if (tmr_hit) begin
            err_f <= 1'b1;
            state <= S_RESTORE;
          end
        end
        S_RESTORE: begin
          for (int i = 0; i < NHEAD; i++) begin
            if (h == HW'(i)) begin
              head_mode_wr[i]           <= 1'b1;
              head_mode_wdata[i*8 +: 8] <= saved_cur;
            end
          end
          h     <= h + 1'b1;
          state <= S_EX_SEL;
        end
        S_FIN: begin
          done  <= 1'b1;
          error <= err_f;
          busy  <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mclk_swap_seq_chk.sv
module mclk_swap_seq_chk
  import mclk_swap_pkg::*;
#(
  parameter int NHEAD = 2,
  parameter int NPLL  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NHEAD-1:0] head_mode_wr,
  input logic             dram_auto_ref_en,
  input logic             dram_self_refresh,
  input logic [1:0]       clk_src_sel,
  input logic [31:0]      pll_ctrl_cur,
  input logic [NPLL-1:0]  pll_wr,
  input logic [31:0]      pll_ctrl,
  input logic             busy,
  input logic             done,
  input logic             error
);

  p_sr_needs_aref_off_r3: assert property (@(posedge clk) disable iff (rst)
    dram_self_refresh |-> !dram_auto_ref_en);

  p_pll_wr_gated_r4: assert property (@(posedge clk) disable iff (rst)
    (|pll_wr) |-> (dram_self_refresh && clk_src_sel == SEL_BYPASS));

  p_ctrl_keeps_foreign_bits_r5: assert property (@(posedge clk) disable iff (rst)
    (|pll_wr) |-> ((pll_ctrl & ~PLL_OWN_MASK) == ($past(pll_ctrl_cur) & ~PLL_OWN_MASK)));

  p_pll_base_always_r7: assert property (@(posedge clk) disable iff (rst)
    (|pll_wr) |-> pll_wr[0]);

  p_pll_single_cycle_r7: assert property (@(posedge clk) disable iff (rst)
    (|pll_wr) |=> !(|pll_wr));

  p_one_head_write_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(head_mode_wr));

  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_ends_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_error_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    error |-> done);

endmodule

bind mclk_swap_seq mclk_swap_seq_chk #(.NHEAD(NHEAD), .NPLL(NPLL)) u_chk (
  .clk               (clk),
  .rst               (rst),
  .head_mode_wr      (head_mode_wr),
  .dram_auto_ref_en  (dram_auto_ref_en),
  .dram_self_refresh (dram_self_refresh),
  .clk_src_sel       (clk_src_sel),
  .pll_ctrl_cur      (pll_ctrl_cur),
  .pll_wr            (pll_wr),
  .pll_ctrl          (pll_ctrl),
  .busy              (busy),
  .done              (done),
  .error             (error)
);

// File: tb/mclk_swap_seq_tb.sv
`timescale 1ns/1ps
module mclk_swap_seq_tb;

  localparam int NH = 2;
  localparam int SW = 16;
  localparam int TMO = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic start = 0, dual_pll = 0, two_stage = 0;
  logic [2:0] log2p = 0, bias_p = 0, max_p = 0;
  logic [7:0] n1 = 0, m1 = 0, n2 = 0, m2 = 0;
  logic [7:0] settle_cycles = 0;
  logic [NH*SW-1:0] head_scan = 0;
  logic [NH-1:0] head_vblank = 0;
  logic [NH*8-1:0] head_mode_rd = 0;
  logic [31:0] pll_ctrl_cur = 0;
  logic [NH-1:0] head_mode_wr;
  logic [NH*8-1:0] head_mode_wdata;
  logic dram_precharge, dram_refresh, dram_auto_ref_en, dram_self_refresh;
  logic [1:0] clk_src_sel;
  logic [1:0] pll_wr;
  logic [31:0] pll_ctrl, pll_coef;
  logic busy, done, error;

  mclk_swap_seq #(.NHEAD(NH), .NPLL(2), .SCAN_W(SW), .SETTLE_W(8), .TMO_CYCLES(TMO)) u_dut (
    .clk(clk), .rst(rst), .start(start), .dual_pll(dual_pll), .two_stage(two_stage),
    .log2p(log2p), .bias_p(bias_p), .max_p(max_p), .n1(n1), .m1(m1), .n2(n2), .m2(m2),
    .settle_cycles(settle_cycles), .head_scan(head_scan), .head_vblank(head_vblank),
    .head_mode_rd(head_mode_rd), .head_mode_wr(head_mode_wr), .head_mode_wdata(head_mode_wdata),
    .dram_precharge(dram_precharge), .dram_refresh(dram_refresh),
    .dram_auto_ref_en(dram_auto_ref_en), .dram_self_refresh(dram_self_refresh),
    .clk_src_sel(clk_src_sel), .pll_ctrl_cur(pll_ctrl_cur), .pll_wr(pll_wr),
    .pll_ctrl(pll_ctrl), .pll_coef(pll_coef), .busy(busy), .done(done), .error(error)
  );

  int n_checks = 0, n_fail = 0;
  bit aborted = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // stimulus generator state
  logic [NH-1:0] run_act = 0, hold_low = 0;
  int per[NH], hi[NH], ph[NH];

  initial begin
    for (int i = 0; i < NH; i++) begin per[i] = 20; hi[i] = 5; ph[i] = 0; end
    forever begin
      @(posedge clk); #1;
      for (int i = 0; i < NH; i++) begin
        ph[i] = (ph[i] + 1) % per[i];
        head_vblank[i] = hold_low[i] ? 1'b0 : (ph[i] < hi[i]);
        if (run_act[i]) head_scan[i*SW +: SW] = head_scan[i*SW +: SW] + 16'd1;
      end
    end
  end

  // event monitor
  bit mon_en = 0;
  int cyc = 0;
  int pre_cnt, ref_cnt, pll_cnt, done_cnt;
  int pre_cyc, ref_cyc, aref_fall, aref_rise, sr_rise, sr_fall, sel_clr, sel_set, pll_cyc;
  logic [1:0] pll_val;
  logic [31:0] ctrl_seen, coef_seen;
  bit pll_gate_ok, err_seen;
  int wr_cnt[NH], first_cyc[NH], last_cyc[NH];
  logic [7:0] first_d[NH], last_d[NH];
  bit first_ok[NH], last_ok[NH];
  logic [3:0] vh[NH];

  task automatic mon_clear();
    pre_cnt = 0; ref_cnt = 0; pll_cnt = 0; done_cnt = 0;
    pre_cyc = -1; ref_cyc = -1; aref_fall = -1; aref_rise = -1; sr_rise = -1;
    sr_fall = -1; sel_clr = -1; sel_set = -1; pll_cyc = -1;
    pll_val = 0; ctrl_seen = 0; coef_seen = 0; pll_gate_ok = 0; err_seen = 0;
    for (int i = 0; i < NH; i++) begin
      wr_cnt[i] = 0; first_cyc[i] = -1; last_cyc[i] = -1;
      first_d[i] = 0; last_d[i] = 0; first_ok[i] = 0; last_ok[i] = 0;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (mon_en) begin
      if (dram_precharge) begin pre_cnt++; if (pre_cyc < 0) pre_cyc = cyc; end
      if (dram_refresh) begin ref_cnt++; if (ref_cyc < 0) ref_cyc = cyc; end
      if (!dram_auto_ref_en && aref_fall < 0) aref_fall = cyc;
      if (dram_auto_ref_en && aref_fall >= 0 && aref_rise < 0) aref_rise = cyc;
      if (dram_self_refresh && sr_rise < 0) sr_rise = cyc;
      if (!dram_self_refresh && sr_rise >= 0 && sr_fall < 0) sr_fall = cyc;
      if (clk_src_sel == 2'b00 && sel_clr < 0) sel_clr = cyc;
      if (clk_src_sel == 2'b11 && sel_clr >= 0 && sel_set < 0) sel_set = cyc;
      if (|pll_wr) begin
        pll_cnt++; pll_cyc = cyc; pll_val = pll_wr;
        ctrl_seen = pll_ctrl; coef_seen = pll_coef;
        pll_gate_ok = dram_self_refresh && !dram_auto_ref_en && (clk_src_sel == 2'b00);
      end
      if (done) begin done_cnt++; err_seen = error; end
      for (int i = 0; i < NH; i++) begin
        if (head_mode_wr[i]) begin
          wr_cnt[i]++;
          if (wr_cnt[i] == 1) begin
            first_d[i] = head_mode_wdata[i*8 +: 8];
            first_ok[i] = vh[i][1] && !vh[i][2];
            first_cyc[i] = cyc;
          end
          last_d[i] = head_mode_wdata[i*8 +: 8];
          last_ok[i] = vh[i][1];
          last_cyc[i] = cyc;
        end
      end
    end
    for (int i = 0; i < NH; i++) vh[i] = {vh[i][2:0], head_vblank[i]};
  end

  function automatic logic [31:0] exp_ctrl(input logic [31:0] cur, input logic [2:0] l2p,
                                           input logic [2:0] bp, input logic [2:0] mp,
                                           input logic ts);
    int s;
    logic [31:0] w;
    s = int'(bp) + int'(l2p);
    if (s > int'(mp)) s = int'(mp);
    w = 32'h8000_0000 | (32'(l2p) << 16) | (32'(s) << 20) | (ts ? 32'h4000_0000 : 32'h0000_0100);
    return (cur & ~32'hC077_1100) | w;
  endfunction

  function automatic logic [31:0] exp_coef(input logic ts);
    return ts ? {n2, m2, n1, m1} : {16'h0, n1, m1};
  endfunction

  // one full sequence; tmo_mode: head 0 active with blanking stuck low
  task automatic run_seq(input logic [NH-1:0] act, input bit tmo_mode);
    int wd;
    @(posedge clk); #1;
    run_act = act;
    hold_low = tmo_mode ? 2'b01 : 2'b00;
    mon_clear();
    mon_en = 1;
    start = 1; @(posedge clk); #1; start = 0;
    repeat (5) @(posedge clk);
    #1 start = 1;                                  // R11: ignored while busy
    @(posedge clk); #1 start = 0;
    wd = 0;
    while (done_cnt == 0 && wd < 20000) begin @(posedge clk); wd++; end
    if (done_cnt == 0) begin
      check(0, "R11", "watchdog expired", 0, 1);
      aborted = 1;
      return;
    end
    repeat (4) @(posedge clk);
    #1;
    mon_en = 0;
    check(busy == 0 && done_cnt == 1, "R11", "single done, idle after", done_cnt, 1);

    if (tmo_mode) begin
      check(err_seen == 1, "R10", "error with done", err_seen, 1);
      check(pll_cnt == 0 && pre_cnt == 0, "R10", "DRAM/PLL steps skipped", pll_cnt + pre_cnt, 0);
      check(wr_cnt[0] == 1 && last_d[0] == head_mode_rd[7:0], "R10", "restore unchanged",
            last_d[0], head_mode_rd[7:0]);
      check(dram_auto_ref_en && !dram_self_refresh, "R10", "refresh state after exit",
            {dram_auto_ref_en, dram_self_refresh}, 2'b10);
      check(wr_cnt[1] == 0, "R1", "inactive head untouched", wr_cnt[1], 0);
      return;
    end

    check(err_seen == 0, "R10", "no error", err_seen, 0);
    for (int i = 0; i < NH; i++) begin
      check(wr_cnt[i] == (act[i] ? 2 : 0), "R1", $sformatf("head%0d write count", i),
            wr_cnt[i], act[i] ? 2 : 0);
      if (act[i]) begin
        check(first_d[i] == (head_mode_rd[i*8 +: 8] | 8'h20) && first_ok[i], "R2",
              $sformatf("head%0d block write", i), {first_ok[i], first_d[i]},
              {1'b1, head_mode_rd[i*8 +: 8] | 8'h20});
        check(first_cyc[i] < pre_cyc, "R2", "block before DRAM prep", first_cyc[i], pre_cyc);
        check(last_d[i] == head_mode_rd[i*8 +: 8] && last_ok[i] && last_cyc[i] > aref_rise,
              "R9", $sformatf("head%0d restore", i), {last_ok[i], last_d[i]},
              {1'b1, head_mode_rd[i*8 +: 8]});
      end
    end
    if (act == 2'b11)
      check(first_cyc[0] < first_cyc[1], "R2", "head index order", first_cyc[0], first_cyc[1]);
    check(pre_cnt == 1 && ref_cnt == 2, "R3", "precharge/refresh counts", {pre_cnt, ref_cnt}, {1, 2});
    check(pre_cyc < ref_cyc && ref_cyc < aref_fall && aref_fall < sr_rise && pre_cyc > 0,
          "R3", "prep order", sr_rise, aref_fall + 1);
    check(sr_rise < sel_clr && sel_clr < pll_cyc && pll_cyc < sel_set && pll_gate_ok,
          "R4", "clock select around PLL write", sel_set, pll_cyc + 1);
    check(ctrl_seen == exp_ctrl(pll_ctrl_cur, log2p, bias_p, max_p, two_stage), "R5",
          "control word", ctrl_seen, exp_ctrl(pll_ctrl_cur, log2p, bias_p, max_p, two_stage));
    check(coef_seen == exp_coef(two_stage), "R6", "coefficient", coef_seen, exp_coef(two_stage));
    check(pll_cnt == 1 && pll_val == (dual_pll ? 2'b11 : 2'b01), "R7", "PLL strobe",
          pll_val, dual_pll ? 2'b11 : 2'b01);
    check(sr_fall - pll_cyc == int'(settle_cycles) + 3, "R8", "settle distance",
          sr_fall - pll_cyc, int'(settle_cycles) + 3);
    check(sr_fall < aref_rise, "R9", "self-refresh off before auto-refresh on", sr_fall, aref_rise);
  endtask

  task automatic randomize_inputs(input logic [NH-1:0] act);
    @(posedge clk); #1;
    dual_pll = 1'($urandom); two_stage = 1'($urandom);
    log2p = 3'($urandom); bias_p = 3'($urandom); max_p = 3'($urandom);
    n1 = 8'($urandom); m1 = 8'($urandom); n2 = 8'($urandom); m2 = 8'($urandom);
    settle_cycles = 8'($urandom_range(0, 20));
    pll_ctrl_cur = $urandom;
    head_mode_rd = 16'($urandom);
    for (int i = 0; i < NH; i++) begin
      per[i] = $urandom_range(12, 40);
      hi[i] = $urandom_range(3, per[i] / 2);
      ph[i] = 0;
    end
    run_act = act;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(!busy && !done && !error && !dram_precharge && !dram_refresh && !dram_self_refresh
          && dram_auto_ref_en && clk_src_sel == 2'b11 && pll_wr == 0 && head_mode_wr == 0,
          "R12", "reset state", {busy, done, error, dram_self_refresh, dram_auto_ref_en, clk_src_sel},
          7'b0000111);

    // directed: both heads, extreme divider fields
    randomize_inputs(2'b11);
    log2p = 3'd7; bias_p = 3'd7; max_p = 3'd5; two_stage = 1; dual_pll = 1; settle_cycles = 0;
    run_seq(2'b11, 0);
    // directed: no head active, single stage, single PLL
    if (!aborted) begin
      randomize_inputs(2'b00);
      two_stage = 0; dual_pll = 0; log2p = 3'd1; bias_p = 3'd2; max_p = 3'd7;
      run_seq(2'b00, 0);
    end
    // random runs
    for (int r = 0; r < 12 && !aborted; r++) begin
      logic [NH-1:0] a;
      a = 2'($urandom);
      randomize_inputs(a);
      run_seq(a, 0);
    end
    // directed: blanking never arrives on head 0
    if (!aborted) begin
      randomize_inputs(2'b01);
      run_seq(2'b01, 1);
      hold_low = 0;
    end
    // a normal run still works after a timeout
    if (!aborted) begin
      randomize_inputs(2'b10);
      run_seq(2'b10, 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule